// File: doc/BRIEF.md
# Double-Sampling Link Error Checker

This block sits at the receive end of an on-chip link whose voltage swing is lowered to save energy. Each incoming word is captured twice. The first capture happens on the main clock. The second happens on a copy of that clock shifted later by a fixed interval. Because the later capture gives the wire extra settling time, it is trusted.

The two captures are compared bit by bit, and the result is registered on the next main-clock edge. If any bit disagrees, the registered output takes the later capture instead of the early one, so the word is repaired in place and does not need to be sent again. An error flag marks the repaired word. A counter accumulates repaired words across a measurement window. A swing controller reads this count and clears it at each window boundary, and uses the count as its run-time error rate.

Generating the delayed clock is outside this block. It arrives on its own input.

Top module: `dsc_link_checker`

## Requirements
- R1: While `rst_n` is low, `fix_data` is zero, `err_flag` is 0 and `err_cnt` is zero.
- R2: A valid word that is stable at both the main and the delayed capture edges appears on `fix_data` after the next main-clock rising edge, with `err_flag` 0 and `err_cnt` unchanged.
- R3: A valid word that reaches the wire only after the main capture edge, but before the delayed capture edge, is replaced by the delayed sample. `fix_data` then equals the late word and `err_flag` is 1.
- R4: A difference in any single bit position between the two samples is enough to raise `err_flag`. The flag is the OR over all bits.
- R5: `err_cnt` rises by exactly one per erroneous valid word, however many bits differ.
- R6: When `link_vld` is low at the main capture edge, `fix_data` holds its value and neither `err_flag` nor `err_cnt` changes, even if the samples disagree.
- R7: A high `win_clr` at a main-clock edge sets `err_cnt` to zero. If an erroneous valid word is registered at the same edge, the count is set to 1 instead.
- R8: In saturating mode (the default), `err_cnt` stops at its all-ones value and does not wrap.
- R9: `err_flag` is high for one main-clock cycle per erroneous word. It returns to 0 on the next edge when no further error follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main receive clock |
| clk_dly | input | 1 | Delayed copy of `clk` for the second capture |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_data | input | DATA_W | Word arriving from the link wires |
| link_vld | input | 1 | Marks `link_data` as a word at the main capture edge |
| win_clr | input | 1 | Starts a new error-count window |
| fix_data | output | DATA_W | Registered, corrected word |
| err_flag | output | 1 | High for the cycle in which a repaired word is presented |
| err_cnt | output | CNT_W | Repaired words in the current window |

## Verification
On every main-clock cycle, the assertions check how the counter steps, clears, holds and saturates. They also check that invalid words leave the output and flag alone, and that a registered word equals the delayed sample when the samples differ and the main sample when they agree. Only the bench scenarios can show that a word arriving late on the wire is actually caught by the delayed edge and missed by the main edge. The same holds for single-bit lateness, flag pulse length and saturation after a long run of errors. Each of these depends on where the stimulus falls between the two clock phases.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
   // How the per-window error counter behaves at its top value.
   typedef enum logic {
      CNT_WRAP     = 1'b0,
      CNT_SATURATE = 1'b1
   } cnt_mode_e;
endpackage

// File: rtl/dsc_capture.sv
// Dual capture of the link: one flop bank on the main clock, one on the
// delayed clock. Both banks see the same wires.
module dsc_capture #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              clk_dly,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] link_data,
   input  logic              link_vld,
   output logic [DATA_W-1:0] main_q,
   output logic              main_vld,
   output logic [DATA_W-1:0] dly_q
);

   generate
      if (DATA_W < 1) begin : g_bad_w
         $error("dsc_capture: DATA_W must be at least 1");
      end
   endgenerate

   // Early sample plus its strobe, main clock domain.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         main_q   <= '0;
         main_vld <= 1'b0;
      end else begin
         main_q   <= link_data;
         main_vld <= link_vld;
      end
   end

   // Late sample, taken the skew interval after the main edge.
   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_late_bit
         always_ff @(posedge clk_dly or negedge rst_n) begin
            if (!rst_n) dly_q[b] <= 1'b0;
            else        dly_q[b] <= link_data[b];
         end
      end
   endgenerate

endmodule

// File: rtl/dsc_compare.sv
// Per-bit comparison, registered verdict and word-level repair mux.
module dsc_compare #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] main_q,
   input  logic              main_vld,
   input  logic [DATA_W-1:0] dly_q,
   output logic [DATA_W-1:0] fix_data,
   output logic              err_flag,
   output logic              err_evt
);

   logic [DATA_W-1:0] bit_diff;
   logic              any_diff;

   generate
      if (DATA_W < 1) begin : g_bad_w
         $error("dsc_compare: DATA_W must be at least 1");
      end
      for (genvar b = 0; b < DATA_W; b++) begin : g_diff
         assign bit_diff[b] = main_q[b] ^ dly_q[b];
      end
   endgenerate

   assign any_diff = |bit_diff;
   assign err_evt  = main_vld & any_diff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fix_data <= '0;
         err_flag <= 1'b0;
      end else begin
         err_flag <= err_evt;
         if (main_vld) fix_data <= any_diff ? dly_q : main_q;
      end
   end

   // R2
   clean_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (main_vld && (main_q == dly_q)) |=> (!err_flag && fix_data == $past(main_q)));
   // R3
   late_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (main_vld && (main_q != dly_q)) |=> (err_flag && fix_data == $past(dly_q)));
   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !main_vld |=> ($stable(fix_data) && !err_flag));

endmodule

// File: rtl/dsc_err_counter.sv
// Per-window count of repaired words; wrap or saturate chosen by parameter.
module dsc_err_counter #(
   parameter int                CNT_W    = 8,
   parameter dsc_pkg::cnt_mode_e CNT_MODE = dsc_pkg::CNT_SATURATE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_next;

   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("dsc_err_counter: CNT_W must be at least 1");
      end
      if (CNT_MODE == dsc_pkg::CNT_SATURATE) begin : g_sat
         always_comb begin
            if (clr)                        cnt_next = inc ? CNT_ONE : '0;
            else if (inc && cnt != CNT_MAX) cnt_next = cnt + CNT_ONE;
            else                            cnt_next = cnt;
         end
         // R8
         cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt == CNT_MAX && !clr) |=> cnt == CNT_MAX);
      end else begin : g_wrap
         always_comb begin
            if (clr)      cnt_next = inc ? CNT_ONE : '0;
            else if (inc) cnt_next = cnt + CNT_ONE;
            else          cnt_next = cnt;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_next;
   end

   // R5
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr && cnt != CNT_MAX) |=> cnt == $past(cnt) + CNT_ONE);
   // R6
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !clr) |=> $stable(cnt));
   // R7
   cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !inc) |=> cnt == '0);
   // R7
   cnt_clr_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && inc) |=> cnt == CNT_ONE);

endmodule

// File: rtl/dsc_link_checker.sv
module dsc_link_checker #(
   parameter int                DATA_W   = 8,
   parameter int                CNT_W    = 8,
   parameter dsc_pkg::cnt_mode_e CNT_MODE = dsc_pkg::CNT_SATURATE
) (
   input  logic              clk,
   input  logic              clk_dly,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] link_data,
   input  logic              link_vld,
   input  logic              win_clr,
   output logic [DATA_W-1:0] fix_data,
   output logic              err_flag,
   output logic [CNT_W-1:0]  err_cnt
);

   logic [DATA_W-1:0] main_q;
   logic [DATA_W-1:0] dly_q;
   logic              main_vld;
   logic              err_evt;

   dsc_capture #(.DATA_W(DATA_W)) u_cap (
      .clk       (clk),
      .clk_dly   (clk_dly),
      .rst_n     (rst_n),
      .link_data (link_data),
      .link_vld  (link_vld),
      .main_q    (main_q),
      .main_vld  (main_vld),
      .dly_q     (dly_q)
   );

   dsc_compare #(.DATA_W(DATA_W)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .main_q   (main_q),
      .main_vld (main_vld),
      .dly_q    (dly_q),
      .fix_data (fix_data),
      .err_flag (err_flag),
      .err_evt  (err_evt)
   );

   dsc_err_counter #(.CNT_W(CNT_W), .CNT_MODE(CNT_MODE)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (win_clr),
      .inc   (err_evt),
      .cnt   (err_cnt)
   );

   // R1
   always_ff @(posedge clk) begin
      rst_clear_chk: assert (rst_n || (fix_data == '0 && !err_flag && err_cnt == '0));
   end

endmodule

// File: tb/dsc_link_checker_tb.sv
module dsc_link_checker_tb;
   localparam int CLK_P  = 10;
   localparam int SKEW   = 3;
   localparam int DATA_W = 8;
   localparam int CNT_W  = 4;

   logic              clk = 1'b0;
   logic              clk_dly = 1'b0;
   logic              rst_n = 1'b0;
   logic [DATA_W-1:0] link_data = '0;
   logic              link_vld = 1'b0;
   logic              win_clr = 1'b0;
   logic [DATA_W-1:0] fix_data;
   logic              err_flag;
   logic [CNT_W-1:0]  err_cnt;

   int checks = 0;
   int fails  = 0;
   logic [DATA_W-1:0] exp_data = '0;
   int                exp_cnt  = 0;

   dsc_link_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
      .clk(clk), .clk_dly(clk_dly), .rst_n(rst_n), .link_data(link_data),
      .link_vld(link_vld), .win_clr(win_clr), .fix_data(fix_data),
      .err_flag(err_flag), .err_cnt(err_cnt)
   );

   initial forever #(CLK_P/2) clk = ~clk;
   initial begin
      #SKEW;
      forever #(CLK_P/2) clk_dly = ~clk_dly;
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // One word: driven before the main edge, or 1 time unit after it (late).
   // Outputs are checked on the falling edge after the registering edge.
   task automatic xfer(input logic [DATA_W-1:0] d, input logic late,
                       input logic vld, input logic clr);
      logic bad;
      bad = late && vld && (link_data != d);
      @(negedge clk);
      link_vld = vld;
      if (!late) link_data = d;
      @(posedge clk);
      #1;
      if (late) link_data = d;
      @(negedge clk);
      link_vld = 1'b0;
      win_clr  = clr;
      @(negedge clk);
      win_clr = 1'b0;
      if (vld) exp_data = d;
      if (clr) exp_cnt = bad ? 1 : 0;
      else if (bad && exp_cnt < (1 << CNT_W) - 1) exp_cnt++;
      check(bad ? "R3 data" : (vld ? "R2 data" : "R6 data"), int'(fix_data), int'(exp_data));
      check(bad ? "R3 flag" : "R2/R6 flag", int'(err_flag), int'(bad));
      check(clr ? "R7 cnt" : "R5 cnt", int'(err_cnt), exp_cnt);
   endtask

   task automatic t_reset();
      #(CLK_P*2 + 2);
      check("R1 data", int'(fix_data), 0);
      check("R1 flag", int'(err_flag), 0);
      check("R1 cnt",  int'(err_cnt), 0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_clean();
      xfer(8'hA5, 1'b0, 1'b1, 1'b0);   // R2
      xfer(8'h5A, 1'b0, 1'b1, 1'b0);   // R2
      xfer(8'hFF, 1'b0, 1'b1, 1'b0);   // R2
      xfer(8'h00, 1'b0, 1'b1, 1'b0);   // R2
   endtask

   task automatic t_late_word();
      xfer(8'hC3, 1'b1, 1'b1, 1'b0);   // R3 many bits late, R5 counts once
      xfer(8'h3C, 1'b1, 1'b1, 1'b0);   // R3
   endtask

   task automatic t_single_bit();
      xfer(8'h3D, 1'b1, 1'b1, 1'b0);   // R4 only bit 0 differs
      xfer(8'hBD, 1'b1, 1'b1, 1'b0);   // R4 only bit 7 differs
   endtask

   task automatic t_flag_pulse();
      xfer(8'h81, 1'b1, 1'b1, 1'b0);
      @(negedge clk);
      check("R9 flag drop", int'(err_flag), 0);
      check("R9 data held", int'(fix_data), 8'h81);
   endtask

   task automatic t_invalid();
      xfer(8'h42, 1'b1, 1'b0, 1'b0);   // R6 late but not valid
      xfer(8'h17, 1'b0, 1'b0, 1'b0);   // R6
   endtask

   task automatic t_clear();
      xfer(8'h66, 1'b0, 1'b1, 1'b1);   // R7 plain clear
      xfer(8'h99, 1'b1, 1'b1, 1'b0);
      xfer(8'h11, 1'b1, 1'b1, 1'b1);   // R7 clear together with an error
   endtask

   task automatic t_saturate();
      for (int i = 0; i < (1 << CNT_W) + 2; i++) begin
         xfer((i % 2 == 0) ? 8'hF0 : 8'h0F, 1'b1, 1'b1, 1'b0);   // R8
      end
      check("R8 sat", int'(err_cnt), (1 << CNT_W) - 1);
   endtask

   initial begin
      t_reset();
      t_clean();
      t_late_word();
      t_single_bit();
      t_flag_pulse();
      t_invalid();
      t_clear();
      t_saturate();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_P*100000);
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule